// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block holds the interrupt bookkeeping of a two-channel serial controller. Each channel, A (index 0) and B (index 1), raises a receive-character event and a transmit-buffer-empty event. The block tracks a pending flag and an in-service flag for each of the four sources. It mirrors the pending sources into one shared 8-bit pending register. It keeps one 8-bit interrupt vector that names the source most recently taken into service. From the flags and the per-channel enable settings it drives a single interrupt request line.

Receive events always enter service. A transmit event on a channel whose receive side is in service is recorded as pending but not served. When software resets the highest in-service flag and a transmit is still waiting, that transmit is promoted into service straight away.

Software reaches the block through a one-cycle write strobe that carries a channel select, a 2-bit command code and 8 data bits. The vector and the pending register are always visible on output ports.

Top module: `sio_irq_vector`

## Requirements
- R1: A synchronous reset clears every pending, in-service, enable and mode bit. It sets `pending_o` to 0x00, `vector_o` to 0x06 (the no-interrupt code in low form) and `irq_o` to 0.
- R2: A receive event on a channel always takes service, and is visible at the clock edge that samples it. It sets the channel's receive pending flag and its receive in-service flag. It sets the channel's receive bit in `pending_o` (A: bit 5, B: bit 2). It loads the vector with the receive code (A: 3'b110, B: 3'b010).
- R3: A transmit event always sets the channel's transmit pending flag. Only when the channel's receive side is not in service does it also set the transmit in-service flag, set the transmit bit in `pending_o` (A: bit 4, B: bit 1) and load the transmit code (A: 3'b100, B: 3'b000). Otherwise `pending_o` and `vector_o` keep their values.
- R4: The vector carries a 3-bit code. The low form is {4'b0000, code, 1'b0}. The high form is {1'b0, code, 4'b0000}. The form follows the status-high bit of the channel that caused the update. That bit is written with command 1 (data bit 0) and takes effect from the next cycle.
- R5: `irq_o` is registered and follows the state it is registered with. It is 1 when, on either channel, transmit is enabled and a transmit is pending, or the receive mode is 2'b01 (first character) or 2'b10 (all characters) and a receive is pending. Command 0 writes transmit enable from data bit 1 and receive mode from data bits 4:3. Receive modes 2'b00 and 2'b11 raise no request.
- R6: Command 3 (reset highest in-service) acts on the selected channel:
  - If receive is in service, the command clears it. If a transmit is still pending, the transmit event path of R3 then runs, serving that transmit.
  - Otherwise, if transmit is in service, the command clears it.
- R7: Command 2 (reset transmit pending) clears the selected channel's transmit pending flag and its bit in `pending_o`. It loads the no-interrupt code 3'b011 in that channel's form.
- R8: Within one cycle, the command is applied first, then receive events, then transmit events (including a promotion from R6). Within each stage channel A is applied before channel B, so the last applied update sets the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_event | input | 2 | Receive-character event per channel (bit 0 = A) |
| tx_event | input | 2 | Transmit-buffer-empty event per channel (bit 0 = A) |
| wr_en | input | 1 | Command write strobe |
| wr_chan | input | 1 | Channel addressed by the command (0 = A) |
| wr_cmd | input | 2 | Command code 0..3 |
| wr_data | input | 8 | Command data |
| vector_o | output | 8 | Interrupt vector register |
| pending_o | output | 8 | Shared pending register |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check four things on every cycle:
- a transmit never enters service while its channel's receive side is in service;
- every receive event lands in service and in the pending register one edge later;
- a reset-transmit-pending command always leaves its pending bit clear;
- the request line never rises without a pending source, and the vector is always a legal high or low form.

Only the directed scenarios show the exact vector codes and which form each takes. They also show the promotion of a held transmit on reset-highest-in-service, the receive modes that must not request, and the result when commands and events from both channels share one cycle.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
    localparam int NCH = 2;   // channels
    localparam int VW  = 8;   // vector / pending width
    localparam int CW  = 3;   // condition code width

    typedef enum logic [1:0] {
        CMD_ENABLES = 2'd0,
        CMD_MODE    = 2'd1,
        CMD_CLR_TXP = 2'd2,
        CMD_CLR_IUS = 2'd3
    } cmd_e;

    localparam logic [CW-1:0] CODE_NONE = 3'b011;

    function automatic logic [CW-1:0] rx_code(int ch);
        return (ch == 0) ? 3'b110 : 3'b010;
    endfunction

    function automatic logic [CW-1:0] tx_code(int ch);
        return (ch == 0) ? 3'b100 : 3'b000;
    endfunction

    function automatic int rx_bit(int ch);
        return (ch == 0) ? 5 : 2;
    endfunction

    function automatic int tx_bit(int ch);
        return (ch == 0) ? 4 : 1;
    endfunction

    typedef struct packed {
        logic [NCH-1:0]      rx_pend;
        logic [NCH-1:0]      tx_pend;
        logic [NCH-1:0]      rx_ius;
        logic [NCH-1:0]      tx_ius;
        logic [NCH-1:0]      tx_en;
        logic [NCH-1:0]      st_hi;
        logic [NCH-1:0][1:0] rx_mode;
        logic [VW-1:0]       pend;
        logic [VW-1:0]       vec;
    } state_t;
endpackage

// File: rtl/sio_vec_fmt.sv
module sio_vec_fmt #(
    parameter int VW = 8,
    parameter int CW = 3
) (
    input  logic [CW-1:0] code,
    input  logic          hi,
    output logic [VW-1:0] vec
);
    localparam int PADW = VW - CW - 1;

    always_comb begin
        if (hi) vec = {1'b0, code, {PADW{1'b0}}};
        else    vec = {{PADW{1'b0}}, code, 1'b0};
    end
endmodule

// File: rtl/sio_irq_calc.sv
module sio_irq_calc #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0]      rx_pend,
    input  logic [NCH-1:0]      tx_pend,
    input  logic [NCH-1:0]      tx_en,
    input  logic [NCH-1:0][1:0] rx_mode,
    output logic                irq
);
    logic [NCH-1:0] req;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_req
        assign req[ch] = (tx_en[ch] && tx_pend[ch]) ||
                         (((rx_mode[ch] == 2'b01) || (rx_mode[ch] == 2'b10)) && rx_pend[ch]);
    end

    assign irq = |req;
endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
    import sio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rx_event,
    input  logic [1:0] tx_event,
    input  logic       wr_en,
    input  logic       wr_chan,
    input  logic [1:0] wr_cmd,
    input  logic [7:0] wr_data,
    output logic [7:0] vector_o,
    output logic [7:0] pending_o,
    output logic       irq_o
);
    state_t state_d, state_q;
    logic   irq_d, irq_q;

    logic [NCH-1:0][VW-1:0] rx_vec, tx_vec, none_vec;
    logic [NCH-1:0]         promote;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_fmt
        sio_vec_fmt #(.VW(VW), .CW(CW)) u_rx (
            .code(rx_code(ch)), .hi(state_q.st_hi[ch]), .vec(rx_vec[ch]));
        sio_vec_fmt #(.VW(VW), .CW(CW)) u_tx (
            .code(tx_code(ch)), .hi(state_q.st_hi[ch]), .vec(tx_vec[ch]));
        sio_vec_fmt #(.VW(VW), .CW(CW)) u_none (
            .code(CODE_NONE), .hi(state_q.st_hi[ch]), .vec(none_vec[ch]));
    end

    always_comb begin
        state_d = state_q;
        promote = '0;
        // stage 1: command
        if (wr_en) begin
            case (wr_cmd)
                CMD_ENABLES: begin
                    state_d.tx_en[wr_chan]   = wr_data[1];
                    state_d.rx_mode[wr_chan] = wr_data[4:3];
                end
                CMD_MODE: state_d.st_hi[wr_chan] = wr_data[0];
                CMD_CLR_TXP: begin
                    state_d.tx_pend[wr_chan]              = 1'b0;
                    state_d.pend[tx_bit(int'(wr_chan))]   = 1'b0;
                    state_d.vec                           = none_vec[wr_chan];
                end
                CMD_CLR_IUS: begin
                    if (state_d.rx_ius[wr_chan]) begin
                        state_d.rx_ius[wr_chan] = 1'b0;
                        promote[wr_chan]        = state_d.tx_pend[wr_chan];
                    end else if (state_d.tx_ius[wr_chan]) begin
                        state_d.tx_ius[wr_chan] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        // stage 2: receive events
        for (int ch = 0; ch < NCH; ch++) begin
            if (rx_event[ch]) begin
                state_d.rx_pend[ch]     = 1'b1;
                state_d.rx_ius[ch]      = 1'b1;
                state_d.pend[rx_bit(ch)] = 1'b1;
                state_d.vec             = rx_vec[ch];
            end
        end
        // stage 3: transmit events and promotions
        for (int ch = 0; ch < NCH; ch++) begin
            if (tx_event[ch] || promote[ch]) begin
                state_d.tx_pend[ch] = 1'b1;
                if (!state_d.rx_ius[ch]) begin
                    state_d.tx_ius[ch]       = 1'b1;
                    state_d.pend[tx_bit(ch)] = 1'b1;
                    state_d.vec              = tx_vec[ch];
                end
            end
        end
    end

    sio_irq_calc #(.NCH(NCH)) u_irq (
        .rx_pend(state_d.rx_pend),
        .tx_pend(state_d.tx_pend),
        .tx_en  (state_d.tx_en),
        .rx_mode(state_d.rx_mode),
        .irq    (irq_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= '0;
            state_q.vec <= {4'b0000, CODE_NONE, 1'b0};
            irq_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    assign vector_o  = state_q.vec;
    assign pending_o = state_q.pend;
    assign irq_o     = irq_q;

    // ---------------- assertions ----------------
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_TX_HELD_BY_RX: assert property (@(posedge clk) disable iff (rst)
            $rose(state_q.tx_ius[c]) |-> !state_q.rx_ius[c]); // R3
        AST_RX_TAKES_SVC: assert property (@(posedge clk) disable iff (rst)
            rx_event[c] |=> (state_q.rx_ius[c] && pending_o[rx_bit(c)])); // R2
        AST_TXP_CLEARED: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_cmd == CMD_CLR_TXP && wr_chan == 1'(c) && !tx_event[c])
            |=> (!state_q.tx_pend[c] && !pending_o[tx_bit(c)])); // R7
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|(state_q.rx_pend | state_q.tx_pend))); // R5

    AST_VEC_LEGAL_FORM: assert property (@(posedge clk) disable iff (rst)
        ((vector_o[7:4] == 4'b0000) && !vector_o[0]) ||
        ((vector_o[3:0] == 4'b0000) && !vector_o[7])); // R4
endmodule

// File: tb/sio_irq_vector_test.sv
module sio_irq_vector_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] rx_event, tx_event;
    logic       wr_en, wr_chan;
    logic [1:0] wr_cmd;
    logic [7:0] wr_data;
    logic [7:0] vector_o, pending_o;
    logic       irq_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_irq_vector uut (
        .clk(clk), .rst(rst), .rx_event(rx_event), .tx_event(tx_event),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .vector_o(vector_o), .pending_o(pending_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] lo(logic [2:0] c); return {4'b0000, c, 1'b0}; endfunction
    function automatic logic [7:0] hi(logic [2:0] c); return {1'b0, c, 4'b0000}; endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rx_event = '0; tx_event = '0; wr_en = 0; wr_chan = 0; wr_cmd = '0; wr_data = '0;
    endtask

    // one cycle of stimulus applied at a falling edge; results visible at the next one
    task automatic cycle(logic [1:0] rx, logic [1:0] tx, logic we, logic ch,
                         logic [1:0] cmd, logic [7:0] d);
        rx_event = rx; tx_event = tx; wr_en = we; wr_chan = ch; wr_cmd = cmd; wr_data = d;
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pending", pending_o, 8'h00);
        chk("R1 vector", vector_o, 8'h06);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_rx_tx_promote();
        do_reset();
        cycle(2'b01, 2'b00, 0, 0, 2'd0, 8'h00);
        chk("R2 A rx pending", pending_o, 8'h20);
        chk("R2 A rx vector", vector_o, lo(3'b110));
        chk("R5 no irq with rx mode 00", {7'b0, irq_o}, 8'h00);
        cycle(2'b00, 2'b00, 1, 0, 2'd0, 8'h08);          // rx mode 01
        chk("R5 irq first-char mode", {7'b0, irq_o}, 8'h01);
        cycle(2'b00, 2'b01, 0, 0, 2'd0, 8'h00);          // tx while rx in service
        chk("R3 held tx pending", pending_o, 8'h20);
        chk("R3 held tx vector", vector_o, lo(3'b110));
        cycle(2'b00, 2'b00, 1, 0, 2'd3, 8'h00);          // reset IUS -> promote
        chk("R6 promote pending", pending_o, 8'h30);
        chk("R6 promote vector", vector_o, lo(3'b100));
        cycle(2'b00, 2'b00, 1, 0, 2'd2, 8'h00);          // reset tx pending
        chk("R7 A pending", pending_o, 8'h20);
        chk("R7 A vector", vector_o, 8'h06);
        cycle(2'b00, 2'b00, 1, 0, 2'd3, 8'h00);          // clears tx in-service
        cycle(2'b00, 2'b01, 0, 0, 2'd0, 8'h00);          // rx no longer in service
        chk("R6 rx released tx served", pending_o, 8'h30);
        chk("R6 rx released vector", vector_o, lo(3'b100));
    endtask

    task automatic t_high_form();
        do_reset();
        cycle(2'b00, 2'b00, 1, 1, 2'd1, 8'h01);
        cycle(2'b10, 2'b00, 0, 0, 2'd0, 8'h00);
        chk("R2 B rx pending", pending_o, 8'h04);
        chk("R4 B rx high vector", vector_o, hi(3'b010));
        cycle(2'b00, 2'b00, 1, 1, 2'd2, 8'h00);
        chk("R7 B none high", vector_o, hi(3'b011));
        chk("R7 B rx bit kept", pending_o, 8'h04);
        cycle(2'b00, 2'b00, 1, 0, 2'd1, 8'h01);
        cycle(2'b01, 2'b00, 0, 0, 2'd0, 8'h00);
        chk("R4 A rx high vector", vector_o, hi(3'b110));
    endtask

    task automatic t_tx_b_irq();
        do_reset();
        cycle(2'b00, 2'b10, 0, 0, 2'd0, 8'h00);
        chk("R3 B tx pending", pending_o, 8'h02);
        chk("R3 B tx vector", vector_o, 8'h00);
        chk("R5 tx disabled no irq", {7'b0, irq_o}, 8'h00);
        cycle(2'b00, 2'b00, 1, 1, 2'd0, 8'h02);
        chk("R5 tx enabled irq", {7'b0, irq_o}, 8'h01);
        cycle(2'b00, 2'b00, 1, 1, 2'd2, 8'h02);
        chk("R7 B tx cleared", pending_o, 8'h00);
        chk("R7 B none low", vector_o, 8'h06);
        chk("R5 irq drops", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_rx_modes();
        do_reset();
        cycle(2'b00, 2'b00, 1, 0, 2'd0, 8'h18);          // mode 11
        cycle(2'b01, 2'b00, 0, 0, 2'd0, 8'h00);
        chk("R5 mode 11 no irq", {7'b0, irq_o}, 8'h00);
        cycle(2'b00, 2'b00, 1, 0, 2'd0, 8'h10);          // mode 10
        chk("R5 mode 10 irq", {7'b0, irq_o}, 8'h01);
    endtask

    task automatic t_ordering();
        do_reset();
        cycle(2'b01, 2'b01, 0, 0, 2'd0, 8'h00);
        chk("R8 rx before tx pending", pending_o, 8'h20);
        chk("R8 rx before tx vector", vector_o, lo(3'b110));
        do_reset();
        cycle(2'b10, 2'b01, 0, 0, 2'd0, 8'h00);
        chk("R8 mixed channels pending", pending_o, 8'h14);
        chk("R8 tx stage last vector", vector_o, lo(3'b100));
        do_reset();
        cycle(2'b01, 2'b00, 0, 0, 2'd0, 8'h00);
        cycle(2'b00, 2'b01, 1, 0, 2'd3, 8'h00);          // command before tx event
        chk("R8 cmd first pending", pending_o, 8'h30);
        chk("R8 cmd first vector", vector_o, lo(3'b100));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1;
        idle();
        @(negedge clk);
        t_reset();
        t_rx_tx_promote();
        t_high_form();
        t_tx_b_irq();
        t_rx_modes();
        t_ordering();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule